// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block holds the interrupt state of a serial transfer engine. It keeps a vector of raw event flags and a vector of enable bits. A single registered interrupt line is asserted whenever at least one raw flag is set and its enable bit is also set.

The transfer engine raises an event by pulsing one bit of `evt_i`. That pulse is recorded only if the matching bit of `evt_gate_i` is high in the same cycle. `evt_gate_i` carries the interrupt-request flag of the command that produced the event. Bit 1 is the word-complete event.

Software reaches the block through four word registers on a simple request/write port:

| Offset | Read returns | Write of a one in a bit |
|--------|--------------|-------------------------|
| 0x20 | raw flags | sets that raw flag |
| 0x24 | raw flags masked by the enables | clears that raw flag (acknowledge) |
| 0x28 | enable mask | sets that enable bit |
| 0x2C | enable mask | clears that enable bit |

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset, all raw flags are 0, all enable bits are 0 and `irq_o` is 0; a read of any of the four registers returns 0.
- R2: A pulse on `evt_i[k]` while `evt_gate_i[k]` is high sets raw flag k at the next clock edge. A pulse while `evt_gate_i[k]` is low leaves the raw flags unchanged. Bit 1 is the word-complete event.
- R3: Writing to offset 0x20 sets each raw flag whose write-data bit is 1. Write-data bits that are 0 leave the flags unchanged. A read of 0x20 returns the raw flags in bits [NUM_EVT-1:0].
- R4: A read of offset 0x24 returns raw flags AND enable mask.
- R5: Writing to offset 0x24 clears each raw flag whose write-data bit is 1. Write-data bits that are 0 leave the flags unchanged.
- R6: Writing to offset 0x28 sets each enable bit whose write-data bit is 1. Write-data bits that are 0 leave the enables unchanged. A read of 0x28 returns the enable mask.
- R7: Writing to offset 0x2C clears each enable bit whose write-data bit is 1. Write-data bits that are 0 leave the enables unchanged. A read of 0x2C returns the enable mask.
- R8: When a gated event and a clear of the same raw flag fall in the same cycle, the flag ends up set.
- R9: `irq_o` is registered. After each clock edge it equals the OR-reduction of (raw flags AND enable mask) as they stand after that edge. A flag whose enable is 0 never drives the line.
- R10: At any other offset, reads return 0 and writes change nothing.
- R11: Read-data bits at position NUM_EVT and above are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational; valid while `req_i` is high and `we_i` is low |
| evt_i | input | NUM_EVT | One-cycle event pulses from the transfer engine |
| evt_gate_i | input | NUM_EVT | Per-event interrupt-request flag of the current command |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take the following for granted:
- The reset value of `irq_o` is only meaningful once reset has been released.
- A register access lasts exactly one cycle.
- Software never writes the raw-set offset and the acknowledge offset in the same cycle.

The bench keeps within these assumptions in three ways:
- It drives every access for a single cycle, changing inputs on the falling edge.
- It issues one register operation at a time.
- It raises event pulses for one cycle only, overlapping them with a register write only in the deliberate same-cycle test.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned OFF_RAW  = 'h20;
  localparam int unsigned OFF_MSK  = 'h24;
  localparam int unsigned OFF_ENS  = 'h28;
  localparam int unsigned OFF_ENC  = 'h2C;
  localparam int unsigned WC_BIT   = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MSK,
    SEL_ENS,
    SEL_ENC
  } reg_sel_e;
endpackage

// File: rtl/irq_stat_dec.sv
module irq_stat_dec
  import irq_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_RAW): sel_o = SEL_RAW;
      ADDR_W'(OFF_MSK): sel_o = SEL_MSK;
      ADDR_W'(OFF_ENS): sel_o = SEL_ENS;
      ADDR_W'(OFF_ENC): sel_o = SEL_ENC;
      default:          sel_o = SEL_NONE;
    endcase
  end

  assign wr_o = req_i &  we_i;
  assign rd_o = req_i & ~we_i;
endmodule

// File: rtl/irq_stat_w1vec.sv
module irq_stat_w1vec #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hw_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    // hardware set outranks software clear
    always_comb begin
      if (hw_i[k] | set_i[k])  d_o[k] = 1'b1;
      else if (clr_i[k])       d_o[k] = 1'b0;
      else                     d_o[k] = q_o[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= d_o[k];
    end

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_i[k] | set_i[k]) |=> q_o[k]);
    p_clear_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] & ~hw_i[k] & ~set_i[k]) |=> !q_o[k]);
    p_idle_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(clr_i[k] | hw_i[k] | set_i[k]) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/irq_stat_line.sv
module irq_stat_line #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_d_i,
  input  logic [W-1:0] en_d_i,
  output logic         irq_o
);
  // built from next-state so the line aligns with the flags it reflects
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(raw_d_i & en_d_i);
  end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] evt_gate_i,
  output logic               irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  reg_sel_e           sel;
  logic               wr, rd;
  logic [NUM_EVT-1:0] wbits, hw_evt;
  logic [NUM_EVT-1:0] raw_set, raw_clr, en_set, en_clr;
  logic [NUM_EVT-1:0] raw_d, raw_q, en_d, en_q;
  logic [NUM_EVT-1:0] rd_vec;
  logic               unused_wdata;

  irq_stat_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .sel_o (sel),
    .wr_o  (wr),
    .rd_o  (rd)
  );

  assign wbits        = wdata_i[NUM_EVT-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_EVT];
  assign hw_evt       = evt_i & evt_gate_i;

  assign raw_set = (wr && sel == SEL_RAW) ? wbits : '0;
  assign raw_clr = (wr && sel == SEL_MSK) ? wbits : '0;
  assign en_set  = (wr && sel == SEL_ENS) ? wbits : '0;
  assign en_clr  = (wr && sel == SEL_ENC) ? wbits : '0;

  irq_stat_w1vec #(.W(NUM_EVT)) u_raw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hw_i  (hw_evt),
    .set_i (raw_set),
    .clr_i (raw_clr),
    .d_o   (raw_d),
    .q_o   (raw_q)
  );

  irq_stat_w1vec #(.W(NUM_EVT)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hw_i  ('0),
    .set_i (en_set),
    .clr_i (en_clr),
    .d_o   (en_d),
    .q_o   (en_q)
  );

  irq_stat_line #(.W(NUM_EVT)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_d_i(raw_d),
    .en_d_i (en_d),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_RAW:          rd_vec = raw_q;
      SEL_MSK:          rd_vec = raw_q & en_q;
      SEL_ENS, SEL_ENC: rd_vec = en_q;
      default:          rd_vec = '0;
    endcase
  end

  assign rdata_o = rd ? {{PAD_W{1'b0}}, rd_vec} : '0;

  p_irq_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(raw_q & en_q));
  p_ungated_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && hw_evt == '0) |=> $stable(raw_q));
  p_en_no_hw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr) |=> $stable(en_q));
  p_upper_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_EVT] == '0);
endmodule

// File: tb/irq_stat_ctrl_tb_top.sv
module irq_stat_ctrl_tb_top;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam logic [ADDR_W-1:0] A_RAW = 8'h20, A_MSK = 8'h24, A_ENS = 8'h28, A_ENC = 8'h2C;
  localparam logic [NUM_EVT-1:0] ALL = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic [NUM_EVT-1:0] evt_i = '0, evt_gate_i = '0;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [NUM_EVT-1:0] m_raw, m_en;

  always #4 clk_i = ~clk_i;

  irq_stat_ctrl #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .evt_gate_i(evt_gate_i),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [DATA_W-1:0] v;
    rd(A_RAW, v); chk({tag, " R3 raw"}, v, DATA_W'(m_raw));
    rd(A_MSK, v); chk({tag, " R4 masked"}, v, DATA_W'(m_raw & m_en));
    rd(A_ENS, v); chk({tag, " R6 en"}, v, DATA_W'(m_en));
    rd(A_ENC, v); chk({tag, " R7 en"}, v, DATA_W'(m_en));
    chk({tag, " R9 irq"}, DATA_W'(irq_o), DATA_W'(|(m_raw & m_en)));
  endtask

  task automatic clear_all();
    wr(A_MSK, '1); wr(A_ENC, '1);
    m_raw = '0; m_en = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    m_raw = '0; m_en = '0;
    #20 rst_ni = 1'b1;
    // R1 reset state
    check_all("R1");

    // R3 R6 R9: every raw/enable pair set by software
    for (int e = 0; e < 16; e++) begin
      for (int r = 0; r < 16; r++) begin
        clear_all();
        wr(A_ENS, DATA_W'(e)); m_en = NUM_EVT'(e);
        wr(A_RAW, DATA_W'(r)); m_raw = NUM_EVT'(r);
        wr(A_RAW, '0); wr(A_ENS, '0); // R3 R6 zeros no effect
        check_all("sweep");
      end
    end

    // R5 acknowledge, R7 enable clear
    for (int r = 0; r < 16; r++) begin
      for (int a = 0; a < 16; a++) begin
        clear_all();
        wr(A_ENS, ALL); m_en = ALL;
        wr(A_RAW, DATA_W'(r)); m_raw = NUM_EVT'(r);
        wr(A_MSK, DATA_W'(a)); m_raw = m_raw & ~NUM_EVT'(a);
        wr(A_MSK, '0); // R5 zeros no effect
        wr(A_ENC, DATA_W'(a)); m_en = m_en & ~NUM_EVT'(a);
        wr(A_ENC, '0); // R7 zeros no effect
        check_all("R5/R7");
      end
    end

    // R2 gated event capture
    for (int g = 0; g < 16; g++) begin
      for (int e = 0; e < 16; e++) begin
        clear_all();
        wr(A_ENS, ALL); m_en = ALL;
        @(negedge clk_i);
        evt_i = NUM_EVT'(e); evt_gate_i = NUM_EVT'(g);
        @(negedge clk_i);
        evt_i = '0; evt_gate_i = '0;
        m_raw = NUM_EVT'(e & g);
        check_all("R2");
      end
    end

    // R9 word-complete with enable masked, then unmasked
    clear_all();
    wr(A_ENS, DATA_W'(ALL & ~(NUM_EVT'(1) << 1))); m_en = ALL & ~(NUM_EVT'(1) << 1);
    @(negedge clk_i); evt_i = 4'b0010; evt_gate_i = 4'b0010;
    @(negedge clk_i); evt_i = '0; evt_gate_i = '0; m_raw = 4'b0010;
    chk("R9 masked wc no irq", DATA_W'(irq_o), '0);
    wr(A_ENS, 32'h2); m_en = ALL;
    chk("R9 irq after unmask", DATA_W'(irq_o), 32'h1);
    check_all("R9");

    // R8 event and acknowledge in the same cycle
    clear_all();
    wr(A_ENS, ALL); m_en = ALL;
    wr(A_RAW, 32'h2); m_raw = 4'b0010;
    @(negedge clk_i);
    evt_i = 4'b0010; evt_gate_i = 4'b0010;
    req_i = 1'b1; we_i = 1'b1; addr_i = A_MSK; wdata_i = 32'h3;
    @(negedge clk_i);
    evt_i = '0; evt_gate_i = '0; req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    chk("R8 irq held", DATA_W'(irq_o), 32'h1);
    check_all("R8");

    // R10 unmapped offsets
    clear_all();
    wr(A_ENS, 32'h5); m_en = 4'h5;
    wr(A_RAW, 32'h6); m_raw = 4'h6;
    for (int a = 0; a < 256; a += 4) begin
      if (a != 'h20 && a != 'h24 && a != 'h28 && a != 'h2C) begin
        wr(ADDR_W'(a), '1);
        rd(ADDR_W'(a), v);
        chk("R10 unmapped read", v, '0);
      end
    end
    check_all("R10");

    // R11 upper read bits
    wr(A_RAW, '1); wr(A_ENS, '1); m_raw = ALL; m_en = ALL;
    rd(A_RAW, v); chk("R11 upper raw", v >> NUM_EVT, '0);
    rd(A_ENS, v); chk("R11 upper en", v >> NUM_EVT, '0);

    // R1 reset clears everything again
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    m_raw = '0; m_en = '0;
    check_all("R1 rereset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule